// File: doc/BRIEF.md
# 100 Mb/s Twisted-Pair Transmit Symbol Encoder

This block turns the nibble stream of a media-independent transmit interface into a serial stream of three-level line symbols for a 100 Mb/s twisted-pair transmitter. It runs on one clock at the 125 MHz bit rate. Every fifth cycle it raises a nibble strobe: the nibble, enable and error inputs present at the next rising edge are taken as one 25 MHz transfer. Each nibble becomes a 5-bit code group. Frames are wrapped in start and end delimiters, and idle groups fill the line between frames.

Each code group is sent most significant bit first. Each bit is whitened by an 11-bit LFSR scrambler, NRZI coded, and then mapped onto a three-level MLT-3 line code. The result is a 2-bit signed level. The group encoder, the scrambler and the NRZI stage each have their own bypass input. The LFSR start state comes from the 5-bit station address, so ports with different addresses send different scrambling sequences.

Top module: `txsym_encoder`

## Requirements
- R1: `nib_tick` is high in every fifth cycle after reset, first in the fifth active cycle. The transmit inputs are consumed at the rising edge that ends a cycle with `nib_tick` high. The first group sent after reset is the idle group.
- R2: Inside a frame, data nibbles map to 5-bit groups sent MSB first: 0→11110, 1→01001, 2→10100, 3→10101, 4→01010, 5→01011, 6→01110, 7→01111, 8→10010, 9→10011, A→10110, B→10111, C→11010, D→11011, E→11100, F→11101.
- R3: With no frame active, the idle group 11111 is sent. When `tx_en` is first seen high, that nibble is replaced by J (11000) and the next nibble by K (10001).
- R4: The first nibble slot with `tx_en` low after frame data sends T (01101). The slot after it sends R (00111), and idle follows.
- R5: A data slot with `tx_en` and `tx_er` both high sends the error group H (00100) in place of the data group.
- R6: With `byp_enc` high, each slot sends {`tx_er`, `txd`} unchanged, and no delimiters or idle groups are inserted.
- R7: The scrambler is an 11-bit shift register s. Per bit, key = s[10]^s[8] and s becomes {s[9:0], key}. The serial bit is XORed with key. The register is loaded during reset with {1, addr, addr} (bit 10 = 1, bits 9:5 and 4:0 = `phy_addr`) and steps every active cycle. With `byp_scr` high, bits pass without the XOR.
- R8: The NRZI level toggles on every 1 bit and starts at 0. With `byp_nrzi` high, the level equals the bit.
- R9: The MLT-3 stage steps through 0, +1, 0, −1 each time the level from R8 changes, and holds otherwise. `line` codes are 00 = 0, 01 = +1, 11 = −1. Code 10 never appears.
- R10: While `rst_n` is low, `line` is 0 and `nib_tick` is low. After `rst_n` rises, the block stays in reset for two more rising edges and starts working on the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txd | input | 4 | Transmit nibble |
| tx_en | input | 1 | Frame enable |
| tx_er | input | 1 | Error flag, or 5th raw bit when encoding is bypassed |
| phy_addr | input | 5 | Station address used as the scrambler seed |
| byp_enc | input | 1 | Bypass group encoding and framing |
| byp_scr | input | 1 | Bypass scrambling |
| byp_nrzi | input | 1 | Bypass NRZI coding |
| nib_tick | output | 1 | Nibble strobe, one cycle in five |
| line | output | 2 | Signed three-level line symbol |

## Verification
The bench runs four configurations, each against a behavioural bit-queue model compared every cycle.
- **All stages on, nonzero address:** an idle stretch, a frame carrying all sixteen nibble values, and a frame with an error slot. These separate the data table, the delimiters and error substitution.
- **Scrambler bypassed, address 0:** the unscrambled idle stream makes the MLT-3 stepping directly visible.
- **NRZI bypassed, address 1F:** MLT-3 then follows bit changes rather than 1 bits, and a second seed is exercised.
- **All three bypasses on:** raw 5-bit groups, including the error bit, reach the line untouched.

// File: rtl/txsym_pkg.sv
package txsym_pkg;

  typedef enum logic [1:0] {
    FR_IDLE = 2'd0,
    FR_K    = 2'd1,
    FR_DATA = 2'd2,
    FR_TAIL = 2'd3
  } fr_state_t;

  localparam logic [4:0] CG_IDLE = 5'b11111;
  localparam logic [4:0] CG_J    = 5'b11000;
  localparam logic [4:0] CG_K    = 5'b10001;
  localparam logic [4:0] CG_T    = 5'b01101;
  localparam logic [4:0] CG_R    = 5'b00111;
  localparam logic [4:0] CG_H    = 5'b00100;

  // Nibble to code group for data slots.
  function automatic logic [4:0] data_group(input logic [3:0] nib);
    logic [4:0] g;
    case (nib)
      4'h0: g = 5'b11110;
      4'h1: g = 5'b01001;
      4'h2: g = 5'b10100;
      4'h3: g = 5'b10101;
      4'h4: g = 5'b01010;
      4'h5: g = 5'b01011;
      4'h6: g = 5'b01110;
      4'h7: g = 5'b01111;
      4'h8: g = 5'b10010;
      4'h9: g = 5'b10011;
      4'hA: g = 5'b10110;
      4'hB: g = 5'b10111;
      4'hC: g = 5'b11010;
      4'hD: g = 5'b11011;
      4'hE: g = 5'b11100;
      default: g = 5'b11101;
    endcase
    return g;
  endfunction

endpackage

// File: rtl/txsym_rst_sync.sv
module txsym_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sr_q;
  logic [STAGES-1:0] sr_d;

  always_comb begin
    sr_d = {sr_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign rst_sync_n = sr_q[STAGES-1];
endmodule

// File: rtl/txsym_framer.sv
module txsym_framer
  import txsym_pkg::*;
#(
  parameter int NIB_W = 4,
  parameter int CG_W  = 5
) (
  input  logic             clk,
  input  logic             rst_i,
  input  logic [NIB_W-1:0] txd,
  input  logic             tx_en,
  input  logic             tx_er,
  input  logic             byp_enc,
  output logic             nib_tick,
  output logic             ser_bit
);
  localparam int PH_W = $clog2(CG_W);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(CG_W - 1);

  logic [PH_W-1:0] ph_q, ph_d;
  logic [CG_W-1:0] cg_q, cg_d;
  fr_state_t       st_q, st_d;
  logic            load;
  logic [CG_W-1:0] grp;
  logic [CG_W-1:0] shifted;

  assign load = (ph_q == PH_LAST);

  // Group selection and framing for the slot that starts after this edge.
  always_comb begin
    st_d = st_q;
    grp  = CG_IDLE;
    if (byp_enc) begin
      grp  = {tx_er, txd};
      st_d = FR_IDLE;
    end else begin
      case (st_q)
        FR_IDLE: begin
          if (tx_en) begin
            grp  = CG_J;
            st_d = FR_K;
          end
        end
        FR_K: begin
          grp  = CG_K;
          st_d = FR_DATA;
        end
        FR_DATA: begin
          if (tx_en) grp = tx_er ? CG_H : data_group(txd);
          else begin
            grp  = CG_T;
            st_d = FR_TAIL;
          end
        end
        default: begin
          grp  = CG_R;
          st_d = FR_IDLE;
        end
      endcase
    end
  end

  always_comb begin
    ph_d = load ? '0 : ph_q + 1'b1;
    cg_d = load ? grp : cg_q;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      ph_q <= '0;
      cg_q <= CG_IDLE;
      st_q <= FR_IDLE;
    end else begin
      ph_q <= ph_d;
      if (load) begin
        cg_q <= cg_d;
        st_q <= st_d;
      end
    end
  end

  assign shifted  = cg_q << ph_q;
  assign ser_bit  = shifted[CG_W-1];
  assign nib_tick = load;

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_i)
    nib_tick |=> !nib_tick) else $error("tick on two cycles in a row"); // R1

  AST_K_AFTER_J: assert property (@(posedge clk) disable iff (!rst_i)
    (st_q == FR_K) |-> (cg_q == CG_J)) else $error("K state without J group"); // R3

  AST_TAIL_AFTER_T: assert property (@(posedge clk) disable iff (!rst_i)
    (st_q == FR_TAIL) |-> (cg_q == CG_T)) else $error("tail state without T group"); // R4
endmodule

// File: rtl/txsym_scrambler.sv
module txsym_scrambler #(
  parameter int LFSR_W = 11,
  parameter int TAP    = 8,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_i,
  input  logic [ADDR_W-1:0] addr,
  input  logic              byp,
  input  logic              bit_i,
  output logic              bit_o
);
  logic [LFSR_W-1:0] s_q, s_d, seed;
  logic              key;

  // Seed: top bit forced high, lower bits repeat the address.
  for (genvar i = 0; i < LFSR_W; i++) begin : g_seed
    if (i == LFSR_W - 1) begin : g_top
      assign seed[i] = 1'b1;
    end else begin : g_addr
      assign seed[i] = addr[i % ADDR_W];
    end
  end

  assign key = s_q[LFSR_W-1] ^ s_q[TAP];

  always_comb begin
    s_d = {s_q[LFSR_W-2:0], key};
  end

  // Seed is loaded synchronously while the internal reset is held.
  always_ff @(posedge clk) begin
    if (!rst_i) s_q <= seed;
    else        s_q <= s_d;
  end

  assign bit_o = byp ? bit_i : (bit_i ^ key);

  AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (!rst_i)
    s_q != '0) else $error("scrambler stuck at zero"); // R7
endmodule

// File: rtl/txsym_line.sv
module txsym_line (
  input  logic       clk,
  input  logic       rst_i,
  input  logic       byp_nrzi,
  input  logic       bit_i,
  output logic [1:0] line
);
  logic       lvl_q, lvl_d;
  logic [1:0] idx_q, idx_d;
  logic       step;

  always_comb begin
    lvl_d = byp_nrzi ? bit_i : (lvl_q ^ bit_i);
    step  = (lvl_d != lvl_q);
    idx_d = step ? idx_q + 2'd1 : idx_q;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      lvl_q <= 1'b0;
      idx_q <= 2'd0;
    end else begin
      lvl_q <= lvl_d;
      idx_q <= idx_d;
    end
  end

  // Cycle position 0,1,2,3 -> 0,+1,0,-1.
  always_comb begin
    case (idx_q)
      2'd1:    line = 2'b01;
      2'd3:    line = 2'b11;
      default: line = 2'b00;
    endcase
  end

  AST_LINE_CODE: assert property (@(posedge clk) disable iff (!rst_i)
    line != 2'b10) else $error("illegal line code"); // R9

  AST_MLT_STEP: assert property (@(posedge clk) disable iff (!rst_i)
    1'b1 |=> ((line == $past(line)) || ((line == 2'b00) != ($past(line) == 2'b00))))
    else $error("line jumped between nonzero levels"); // R9
endmodule

// File: rtl/txsym_encoder.sv
module txsym_encoder #(
  parameter int NIB_W  = 4,
  parameter int CG_W   = 5,
  parameter int LFSR_W = 11,
  parameter int TAP    = 8,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NIB_W-1:0]  txd,
  input  logic              tx_en,
  input  logic              tx_er,
  input  logic [ADDR_W-1:0] phy_addr,
  input  logic              byp_enc,
  input  logic              byp_scr,
  input  logic              byp_nrzi,
  output logic              nib_tick,
  output logic [1:0]        line
);
  logic rst_i;
  logic raw_bit;
  logic scr_bit;

  txsym_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i)
  );

  txsym_framer #(.NIB_W(NIB_W), .CG_W(CG_W)) u_framer (
    .clk      (clk),
    .rst_i    (rst_i),
    .txd      (txd),
    .tx_en    (tx_en),
    .tx_er    (tx_er),
    .byp_enc  (byp_enc),
    .nib_tick (nib_tick),
    .ser_bit  (raw_bit)
  );

  txsym_scrambler #(.LFSR_W(LFSR_W), .TAP(TAP), .ADDR_W(ADDR_W)) u_scr (
    .clk   (clk),
    .rst_i (rst_i),
    .addr  (phy_addr),
    .byp   (byp_scr),
    .bit_i (raw_bit),
    .bit_o (scr_bit)
  );

  txsym_line u_line (
    .clk      (clk),
    .rst_i    (rst_i),
    .byp_nrzi (byp_nrzi),
    .bit_i    (scr_bit),
    .line     (line)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_i |-> (line == 2'b00 && !nib_tick)) else $error("activity in reset"); // R10
endmodule

// File: tb/tb_txsym_encoder.sv
`timescale 1ns/1ps
module tb_txsym_encoder;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] txd = '0;
  logic       tx_en = 1'b0, tx_er = 1'b0;
  logic [4:0] phy_addr = '0;
  logic       byp_enc = 1'b0, byp_scr = 1'b0, byp_nrzi = 1'b0;
  logic       nib_tick;
  logic [1:0] line;

  always #4 clk = ~clk; // 125 MHz

  txsym_encoder dut (
    .clk(clk), .rst_n(rst_n), .txd(txd), .tx_en(tx_en), .tx_er(tx_er),
    .phy_addr(phy_addr), .byp_enc(byp_enc), .byp_scr(byp_scr),
    .byp_nrzi(byp_nrzi), .nib_tick(nib_tick), .line(line)
  );

  int    n_chk = 0, n_fail = 0, cyc = 0;
  bit    done = 0;
  string cur_req = "R10";

  // ---------------- behavioural reference model ----------------
  bit         q[$];
  int         hold = 0, mcnt = 0, fst = 0, lfsr = 0, lvl = 0, idx = 0;
  logic [1:0] m_line = 2'b00;
  bit         m_tick = 0;

  function automatic int code_of(int n);
    int t[16] = '{'b11110, 'b01001, 'b10100, 'b10101, 'b01010, 'b01011,
                  'b01110, 'b01111, 'b10010, 'b10011, 'b10110, 'b10111,
                  'b11010, 'b11011, 'b11100, 'b11101};
    return t[n];
  endfunction

  function automatic int seed_of(int a);
    int s = 1 << 10; // R7 seed {1,addr,addr}
    for (int i = 0; i < 10; i++) if ((a >> (i % 5)) & 1) s |= (1 << i);
    return s;
  endfunction

  function automatic int next_group();
    int g;
    if (byp_enc) return {tx_er, txd};                 // R6
    case (fst)
      0: if (tx_en) begin g = 'b11000; fst = 1; end    // R3 J
         else g = 'b11111;                             // R3 idle
      1: begin g = 'b10001; fst = 2; end               // R3 K
      2: if (tx_en) g = tx_er ? 'b00100 : code_of(txd); // R5, R2
         else begin g = 'b01101; fst = 3; end          // R4 T
      default: begin g = 'b00111; fst = 0; end         // R4 R
    endcase
    return g;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      hold = 0; mcnt = 0; fst = 0; lvl = 0; idx = 0;
      q.delete();
      for (int i = 0; i < 5; i++) q.push_back(1'b1);
      lfsr = seed_of(phy_addr);
    end else if (hold < 2) begin
      hold++;                                          // R10
      lfsr = seed_of(phy_addr);
    end else begin
      bit b; int key, g, nl;
      b = q.pop_front();
      if (mcnt == 4) begin                             // R1
        g = next_group();
        for (int i = 4; i >= 0; i--) q.push_back(bit'((g >> i) & 1));
      end
      mcnt = (mcnt == 4) ? 0 : mcnt + 1;
      key  = ((lfsr >> 10) ^ (lfsr >> 8)) & 1;
      lfsr = ((lfsr << 1) | key) & 'h7FF;
      if (!byp_scr) b = b ^ bit'(key);                 // R7
      nl = byp_nrzi ? int'(b) : (lvl ^ int'(b));       // R8
      if (nl != lvl) idx = (idx + 1) % 4;              // R9
      lvl = nl;
    end
    m_tick = (mcnt == 4);
    m_line = (idx == 1) ? 2'b01 : (idx == 3) ? 2'b11 : 2'b00;
  end

  // ---------------- comparison every cycle ----------------
  always @(negedge clk) begin
    if (!done) begin
      n_chk++;
      if (line !== m_line) begin
        n_fail++;
        $display("FAIL %s line actual=%b expected=%b at cycle %0d", cur_req, line, m_line, cyc);
      end
      n_chk++;
      if (nib_tick !== m_tick) begin
        n_fail++;
        $display("FAIL R1 nib_tick actual=%b expected=%b at cycle %0d", nib_tick, m_tick, cyc);
      end
    end
  end

  // Watchdog.
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<150000 cycles", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic nib(input bit en, input bit er, input logic [3:0] d);
    @(negedge clk);
    while (!nib_tick) @(negedge clk);
    tx_en = en; tx_er = er; txd = d;
  endtask

  task automatic restart(input logic [4:0] a, input bit be, input bit bs, input bit bn);
    @(negedge clk);
    rst_n = 0; tx_en = 0; tx_er = 0; txd = 0;
    phy_addr = a; byp_enc = be; byp_scr = bs; byp_nrzi = bn;
    cur_req = "R10";
    repeat (4) @(negedge clk);
    n_chk++;
    if (line !== 2'b00 || nib_tick !== 1'b0) begin
      n_fail++;
      $display("FAIL R10 reset outputs actual=%b/%b expected=00/0", line, nib_tick);
    end
    rst_n = 1;
  endtask

  task automatic frame(input int len, input int err_at);
    for (int i = 0; i < len; i++) nib(1, i == err_at, 4'(i));
    nib(0, 0, 0);
  endtask

  initial begin
    // All stages active: R1 R2 R3 R4 R5 R7 R8 R9
    restart(5'h13, 0, 0, 0);
    cur_req = "R1/R3 idle";
    repeat (6) nib(0, 0, 0);
    cur_req = "R2/R3/R4 frame";
    frame(16, -1);
    repeat (4) nib(0, 0, 0);
    cur_req = "R5 error slot";
    frame(6, 3);
    repeat (4) nib(0, 0, 0);
    cur_req = "R4 back-to-back";
    frame(3, -1);
    frame(2, -1);
    repeat (4) nib(0, 0, 0);

    // Scrambler bypassed, address 0: R7 R9
    restart(5'h00, 0, 1, 0);
    cur_req = "R7 bypass/R9";
    repeat (4) nib(0, 0, 0);
    frame(8, 2);
    repeat (4) nib(0, 0, 0);

    // NRZI bypassed, address 1F: R8 R9 R7
    restart(5'h1F, 0, 0, 1);
    cur_req = "R8 bypass/R7 seed";
    repeat (4) nib(0, 0, 0);
    frame(10, 5);
    repeat (4) nib(0, 0, 0);

    // All bypasses: R6
    restart(5'h0A, 1, 1, 1);
    cur_req = "R6 raw groups";
    for (int i = 0; i < 32; i++) nib(1'(i % 3 == 0), 1'(i >> 4), 4'(i));
    repeat (4) nib(0, 0, 0);

    @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule